// File: doc/BRIEF.md
# Airborne Bus Word Packetizer

This block takes 32-bit words already received and decoded from a set of two-wire avionics serial buses (ARINC-429), together with the subchannel that carried each word and the status flags the receiver raised, and turns them into the body of a recording packet. Every accepted word produces a 32-bit identification word followed by the untouched data word, and both leave the block as 16-bit halves on a single output stream.

The identification word carries the time from the start of the previous word to the start of this one, measured in 0.1 µs steps by a tick derived from the system clock. The block decides where packets end: a packet closes once it holds the maximum word count, or when its elapsed time reaches the time limit. At each close it reports the word count for the packet's channel-specific word. It also latches the time value presented with the first word of each packet, which the header logic reads.

The input handshake is a plain valid/ready pair. A word is taken only when the half-word stream can start it in the next cycle, so the block holds no input queue.

Top module: `a429_word_packer`

## Requirements
- R1: The identification word holds the subchannel number in bits 31-24, the format-error flag in bit 23, the parity-error flag in bit 22, the bus-speed flag in bit 21 (1 = fast bus), a zero in bit 20 and the gap time in bits 19-0.
- R2: Each accepted word produces exactly four output halves on consecutive cycles: identification bits 15-0, identification bits 31-16, data bits 15-0, data bits 31-16. The data word is passed through unchanged.
- R3: One tick occurs every CLK_PER_TICK clock cycles, counted from reset release. The gap time of a word that is not first in its packet equals the number of ticks after the cycle in which the previous word was accepted and before the cycle in which this word is accepted.
- R4: The first word of every packet carries a gap time of 0, and its first output half is marked with out_sop.
- R5: When a packet reaches MAX_WORDS words, pkt_close pulses for one cycle with pkt_count equal to MAX_WORDS. The next word starts a new packet.
- R6: Once LIMIT_TICKS ticks have passed since the acceptance of a packet's first word, the packet closes and pkt_count reports the words it holds. A word accepted at or after that point starts a new packet with gap time 0.
- R7: pkt_time holds the in_time value that was presented with the first word of the current packet. It changes only in the cycle in which that word's first half appears.
- R8: After reset, in_ready is high and out_valid and pkt_close are low.
- R9: in_ready is low on the three cycles that follow an accepted word, and is high again on the cycle of that word's last output half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | A received word is offered |
| in_ready | output | 1 | The offered word is taken on this cycle's edge |
| in_word | input | 32 | Received bus word, as it came off the bus |
| in_subch | input | 8 | Subchannel number, 0 for the first bus |
| in_hispeed | input | 1 | Word came from a fast bus |
| in_par_err | input | 1 | Receiver saw a parity error |
| in_fmt_err | input | 1 | Receiver saw a format error |
| in_time | input | TIME_W | Time value belonging to the offered word |
| out_valid | output | 1 | out_half carries a packet-body half |
| out_half | output | 16 | Packet-body half |
| out_sop | output | 1 | This half opens a new packet body |
| pkt_close | output | 1 | One-cycle pulse: the current packet has ended |
| pkt_count | output | 16 | Word count of the last closed packet |
| pkt_time | output | TIME_W | Time of the current packet's first word |

## Verification
The assertions assume that the flag and subchannel inputs are stable while in_valid waits for in_ready, and that MAX_WORDS is at least 2. Without the second assumption, a count close and a time close could fall in the same cycle. The stimulus meets both conditions because the driver holds each word until it is taken and the bench uses a packet limit of four words. The bench places its pauses off the tick period, so gaps cover both aligned and misaligned intervals. One pause stops just short of the time limit and another runs past it, which exercises both outcomes at the limit.

// File: rtl/a429_pkt_pkg.sv
package a429_pkt_pkg;

  localparam int GAP_W = 20;

  // Identification word; field positions are decoded downstream.
  typedef struct packed {
    logic [7:0]       subch;
    logic             fmt_err;
    logic             par_err;
    logic             hispeed;
    logic             rsvd;
    logic [GAP_W-1:0] gap;
  } id_word_t;

endpackage

// File: rtl/a429_tick_gen.sv
module a429_tick_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q, div_d;

  always_comb begin
    tick  = (div_q == LAST);
    div_d = tick ? '0 : div_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  generate
    if (DIV > 1) begin : g_chk
      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/a429_tick_span.sv
module a429_tick_span #(
  parameter int     W   = 20,
  parameter longint SAT = 1048575
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] SAT_V = W'(SAT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)                        cnt_d = '0;
    else if (tick && cnt_q != SAT_V) cnt_d = cnt_q + W'(1);
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3
  span_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt_q != SAT_V) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R3
  span_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/a429_half_ser.sv
module a429_half_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] id_word,
  input  logic [31:0] data_word,
  input  logic        first,
  output logic        can_load,
  output logic        out_valid,
  output logic [15:0] out_half,
  output logic        out_sop
);
  logic        busy_q, busy_d;
  logic [1:0]  phase_q, phase_d;
  logic [63:0] buf_q, buf_d;
  logic        first_q, first_d;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    buf_d   = buf_q;
    first_d = first_q;
    if (load) begin
      busy_d  = 1'b1;
      phase_d = 2'd0;
      buf_d   = {data_word, id_word};
      first_d = first;
    end else if (busy_q) begin
      if (phase_q == 2'd3) busy_d = 1'b0;
      else                 phase_d = phase_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 2'd0;
      buf_q   <= '0;
      first_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      buf_q   <= buf_d;
      first_q <= first_d;
    end
  end

  always_comb begin
    can_load  = !busy_q || (phase_q == 2'd3);
    out_valid = busy_q;
    out_sop   = busy_q && first_q && (phase_q == 2'd0);
    case (phase_q)
      2'd0:    out_half = buf_q[15:0];
      2'd1:    out_half = buf_q[31:16];
      2'd2:    out_half = buf_q[47:32];
      default: out_half = buf_q[63:48];
    endcase
  end

  // R2
  half_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && phase_q != 2'd3) |=> (out_valid && phase_q == $past(phase_q) + 2'd1));

endmodule

// File: rtl/a429_word_packer.sv
module a429_word_packer
  import a429_pkt_pkg::*;
#(
  parameter int CLK_PER_TICK = 10,
  parameter int MAX_WORDS    = 256,      // at least 2
  parameter int LIMIT_TICKS  = 1000000,  // 100 ms in 0.1 us ticks
  parameter int TIME_W       = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  input  logic [7:0]        in_subch,
  input  logic              in_hispeed,
  input  logic              in_par_err,
  input  logic              in_fmt_err,
  input  logic [TIME_W-1:0] in_time,
  output logic              out_valid,
  output logic [15:0]       out_half,
  output logic              out_sop,
  output logic              pkt_close,
  output logic [15:0]       pkt_count,
  output logic [TIME_W-1:0] pkt_time
);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int EL_W  = $clog2(LIMIT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WORDS);
  localparam logic [EL_W-1:0]  EL_MAX  = EL_W'(LIMIT_TICKS);

  logic              tick, can_load, accept, time_hit, new_pkt, clr_el;
  logic [GAP_W-1:0]  gap_cnt;
  logic [EL_W-1:0]   el_cnt;
  logic              open_q, open_d, close_q, close_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_acc, rep_q, rep_d;
  logic [TIME_W-1:0] time_q, time_d;
  id_word_t          id_w;

  a429_tick_gen #(.DIV(CLK_PER_TICK)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  a429_tick_span #(.W(GAP_W), .SAT((64'd1 << GAP_W) - 1)) i_gap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick), .count(gap_cnt)
  );

  a429_tick_span #(.W(EL_W), .SAT(LIMIT_TICKS)) i_elapsed (
    .clk(clk), .rst_n(rst_n), .clr(clr_el), .tick(tick), .count(el_cnt)
  );

  always_comb begin
    accept   = in_valid && can_load;
    time_hit = open_q && (el_cnt == EL_MAX);
    new_pkt  = !open_q || time_hit;
    clr_el   = (accept && new_pkt) || !open_q;
    cnt_acc  = new_pkt ? CNT_W'(1) : cnt_q + CNT_W'(1);

    id_w.subch   = in_subch;
    id_w.fmt_err = in_fmt_err;
    id_w.par_err = in_par_err;
    id_w.hispeed = in_hispeed;
    id_w.rsvd    = 1'b0;
    id_w.gap     = new_pkt ? '0 : gap_cnt;

    cnt_d   = accept ? cnt_acc : cnt_q;
    open_d  = accept ? (cnt_acc != CNT_MAX) : (open_q && !time_hit);
    close_d = time_hit || (accept && cnt_acc == CNT_MAX);
    rep_d   = rep_q;
    if (time_hit)     rep_d = cnt_q;
    else if (close_d) rep_d = cnt_acc;
    time_d  = (accept && new_pkt) ? in_time : time_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      close_q <= 1'b0;
      cnt_q   <= '0;
      rep_q   <= '0;
      time_q  <= '0;
    end else begin
      open_q  <= open_d;
      close_q <= close_d;
      cnt_q   <= cnt_d;
      rep_q   <= rep_d;
      time_q  <= time_d;
    end
  end

  a429_half_ser i_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .id_word(id_w),
    .data_word(in_word), .first(new_pkt), .can_load(can_load),
    .out_valid(out_valid), .out_half(out_half), .out_sop(out_sop)
  );

  assign in_ready  = can_load;
  assign pkt_close = close_q;
  assign pkt_count = 16'(rep_q);
  assign pkt_time  = time_q;

  // R5
  word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R4
  sop_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_half == 16'h0000));

  // R6
  close_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_close |=> !pkt_close);

  // R7
  time_on_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pkt_time) |-> out_sop);

  // R9
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !out_valid) |=> !in_ready);

endmodule

// File: tb/test_a429_word_packer.sv
module test_a429_word_packer;
  localparam int CLK_PERIOD = 10;
  localparam int N_TICK = 3;
  localparam int MAXW   = 4;
  localparam int LIMIT  = 40;
  localparam int TW     = 48;

  typedef struct {
    logic [15:0]   h;
    logic          sop;
    logic [TW-1:0] t;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [7:0] in_subch = '0;
  logic in_hispeed = 1'b0, in_par_err = 1'b0, in_fmt_err = 1'b0;
  logic [TW-1:0] in_time = '0;
  logic in_ready, out_valid, out_sop, pkt_close;
  logic [15:0] out_half, pkt_count;
  logic [TW-1:0] pkt_time;

  int n_tests = 0, n_fail = 0, cyc = 0;
  exp_t exp_q[$];
  int exp_close[$];
  int obs_close[$];
  bit m_open = 0;
  int m_cnt = 0, m_first = 0, m_last = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a429_word_packer #(
    .CLK_PER_TICK(N_TICK), .MAX_WORDS(MAXW), .LIMIT_TICKS(LIMIT), .TIME_W(TW)
  ) i_a429_word_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_subch(in_subch), .in_hispeed(in_hispeed),
    .in_par_err(in_par_err), .in_fmt_err(in_fmt_err), .in_time(in_time),
    .out_valid(out_valid), .out_half(out_half), .out_sop(out_sop),
    .pkt_close(pkt_close), .pkt_count(pkt_count), .pkt_time(pkt_time)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  function automatic int ticks(int lo, int hi);
    int n = 0;
    for (int e = lo; e <= hi; e++)
      if (e % N_TICK == N_TICK - 1) n++;
    return n;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares each output half against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected half", out_half, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_half == e.h, e.tag, "half", out_half, e.h);
          check(out_sop == e.sop, "R4", "sop flag", out_sop, e.sop);
          if (e.sop) check(pkt_time == e.t, "R7", "packet time", pkt_time, e.t);
        end
      end
      if (pkt_close) obs_close.push_back(int'(pkt_count));
    end
  end

  task automatic send(logic [31:0] w, logic [7:0] sc, logic hs, logic pe, logic fe);
    int a, gap;
    bit nw;
    logic [31:0] id;
    in_valid = 1'b1; in_word = w; in_subch = sc;
    in_hispeed = hs; in_par_err = pe; in_fmt_err = fe;
    in_time = TW'(48'h5A0000 + cyc);
    while (!in_ready) @(negedge clk);
    a = cyc;
    if (m_open && ticks(m_first + 1, a - 1) >= LIMIT) begin
      exp_close.push_back(m_cnt);   // R6 time close
      m_open = 0;
    end
    nw  = !m_open;
    gap = nw ? 0 : ticks(m_last + 1, a - 1);
    m_cnt = nw ? 1 : m_cnt + 1;
    if (nw) m_first = a;
    m_last = a;
    m_open = 1;
    id = {sc, fe, pe, hs, 1'b0, 20'(gap)};
    exp_q.push_back('{id[15:0],  nw,   in_time, nw ? "R4" : "R3"});
    exp_q.push_back('{id[31:16], 1'b0, '0, "R1"});
    exp_q.push_back('{w[15:0],   1'b0, '0, "R2"});
    exp_q.push_back('{w[31:16],  1'b0, '0, "R2"});
    if (m_cnt == MAXW) begin
      exp_close.push_back(MAXW);    // R5 count close
      m_open = 0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R9", "ready after accept", in_ready, 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(in_ready == 1'b1, "R8", "ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R8", "valid in reset", out_valid, 0);
    check(pkt_close == 1'b0, "R8", "close in reset", pkt_close, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 first packet: varied flags and subchannels, back-to-back and spaced
    send(32'h1234_ABCD, 8'd0,   1'b0, 1'b0, 1'b0);
    idle(7);
    send(32'hFFFF_0001, 8'd255, 1'b1, 1'b0, 1'b0);
    send(32'h8000_7FFF, 8'd17,  1'b0, 1'b1, 1'b0);
    // R9 ready returns during last half: next word follows after 3 cycles
    send(32'h0F0F_F0F0, 8'd42,  1'b0, 1'b0, 1'b1);
    // R5 packet reached MAXW words; next one is new
    idle(11);
    send(32'hDEAD_BEEF, 8'd3,   1'b1, 1'b1, 1'b1);
    // R6 long pause past limit closes packet; new packet with gap 0
    idle(LIMIT * N_TICK + 13);
    send(32'hCAFE_0002, 8'd9,   1'b0, 1'b0, 1'b0);
    idle((LIMIT - 4) * N_TICK);
    send(32'h0000_0003, 8'd9,   1'b1, 1'b0, 1'b0);   // just below limit: same packet
    idle(5 * N_TICK);
    send(32'h5555_AAAA, 8'd128, 1'b0, 1'b1, 1'b0);   // past limit: new packet
    send(32'hAAAA_5555, 8'd1,   1'b0, 1'b0, 1'b0);
    idle(LIMIT * N_TICK + 20);
    if (m_open) begin
      exp_close.push_back(m_cnt);
      m_open = 0;
    end

    check(exp_q.size() == 0, "R2", "halves left over", exp_q.size(), 0);
    check(obs_close.size() == exp_close.size(), "R5", "close pulse count",
          obs_close.size(), exp_close.size());
    for (int i = 0; i < exp_close.size() && i < obs_close.size(); i++)
      check(obs_close[i] == exp_close[i], "R6", "closed packet count",
            obs_close[i], exp_close[i]);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule